// File: doc/BRIEF.md
# Per-Type FIFO Write Delay Timer

This block decides when read data from a crate module is committed to the event FIFO. A read command goes out on the crate bus, and the block then waits before it raises a one-cycle FIFO write strobe. The wait starts from a base of 400 ns, which is 10 ticks of a 40 ns clock. It is then shortened by a 3-bit subtractor. Each count of the subtractor removes one tick. Modules that drive stable data early can therefore be read faster.

There is one subtractor for each of the 16 module types. They are packed four to a 16-bit configuration word, and the four words sit at register addresses 3, 4, 5 and 6. The type is sampled on the same edge that accepts the read, and its subtractor is captured at that moment. Only one delay runs at a time. A read pulse that arrives while a delay is running is dropped and raises an error pulse.

A build option selects a single-subtractor variant. In that variant every type uses the lowest field of the word at address 3.

Top module: `fifo_wr_delay`

## Requirements
- R1: After reset, `fifo_wr_o` and `overlap_err_o` are low and every configuration word reads 0. An unprogrammed type therefore waits the full 10 ticks.
- R2: A write at address 3, 4, 5 or 6 stores the data word. Bits 3, 7, 11 and 15 always read back as 0. Any other address reads 0, and a write there has no effect on any readback.
- R3: Type t uses the word at address 3 + t[3:2]. Within that word it uses the field at bits [4*f+2 : 4*f], where f = t[1:0].
- R4: Let k be the rising edge that samples `rd_issued_i` high while no delay is running. Then `fifo_wr_o` goes high on edge k + (10 − subtractor) and stays high for exactly one cycle.
- R5: A `rd_issued_i` sampled while a delay is running is ignored and `overlap_err_o` is high for the following cycle. A read that is accepted leaves `overlap_err_o` low.
- R6: The subtractor is fixed when the read is accepted. Later writes to the configuration words, or changes of `mod_type_i`, leave the pending strobe time unchanged.
- R7: With `SINGLE_SUB` set, every type uses bits [2:0] of the word at address 3.
- R8: Each accepted read produces exactly one strobe. A new read may be accepted in the cycle in which the previous strobe is high, and it gives no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock (default 40 ns) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_issued_i | input | 1 | One-cycle pulse: a read command has been issued |
| mod_type_i | input | 4 | Type of the module being read |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration word address, used for both write and readback |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Readback of the addressed word |
| fifo_wr_o | output | 1 | One-cycle FIFO write strobe |
| overlap_err_o | output | 1 | One-cycle flag: a read arrived while a delay was running |

## Verification
The assertions assume the following about the inputs:
- `rd_issued_i` is a pulse sampled on clock edges.
- The base tick count exceeds the largest subtractor, so every delay lasts at least three ticks.
- The delay window can then be bounded by a counter in the checker.

The stimulus holds every read pulse for exactly one cycle. It issues reads only when the timer is idle, apart from the deliberate overlap case and the read placed in the strobe cycle. It leaves at least 11 idle cycles between scenarios, so that each expected strobe in the scoreboard queue can be matched against a single pending delay.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

  // bits of a config word that hold subtractor fields
  function automatic logic [31:0] used_mask(int data_w, int sub_w);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < data_w; b++) begin
      if ((b % (sub_w + 1)) < sub_w) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs #(
  parameter int TYPE_W     = 4,
  parameter int DATA_W     = 16,
  parameter int SUB_W      = 3,
  parameter int ADDR_W     = 4,
  parameter int FIRST_ADDR = 3,
  parameter bit SINGLE_SUB = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SUB_W-1:0]  sub_o
);
  localparam int FIELD_W   = SUB_W + 1;
  localparam int FIELDS    = DATA_W / FIELD_W;
  localparam int FLD_IDX_W = $clog2(FIELDS);
  localparam int NUM_WORDS = (2 ** TYPE_W) / FIELDS;
  localparam logic [DATA_W-1:0] MASK = DATA_W'(fwd_pkg::used_mask(DATA_W, SUB_W));

  logic [DATA_W-1:0] words_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) words_q[w] <= '0;
    end else if (we_i) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (addr_i == ADDR_W'(FIRST_ADDR + w)) words_q[w] <= wdata_i & MASK;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(FIRST_ADDR + w)) rdata_o = words_q[w];
    end
  end

  generate
    if (SINGLE_SUB) begin : g_single
      assign sub_o = words_q[0][SUB_W-1:0];
    end else begin : g_per_type
      logic [DATA_W-1:0] sel_word;
      always_comb begin
        sel_word = words_q[type_i[TYPE_W-1:FLD_IDX_W]];
        sub_o    = SUB_W'(sel_word >> (int'(type_i[FLD_IDX_W-1:0]) * FIELD_W));
      end
    end
  endgenerate

endmodule

// File: rtl/fwd_timer.sv
module fwd_timer #(
  parameter int SUB_W      = 3,
  parameter int BASE_TICKS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic             busy_o,
  output logic             strobe_o,
  output logic             overlap_o
);
  import fwd_pkg::*;

  localparam int CNT_W = $clog2(BASE_TICKS + 1);

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  assign load   = CNT_W'(BASE_TICKS - 1) - CNT_W'(sub_i);
  assign busy_o = (state_q == TMR_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TMR_IDLE;
      cnt_q     <= '0;
      strobe_o  <= 1'b0;
      overlap_o <= 1'b0;
    end else begin
      strobe_o  <= 1'b0;
      overlap_o <= 1'b0;
      case (state_q)
        TMR_IDLE: begin
          if (start_i) begin
            cnt_q   <= load;
            state_q <= TMR_RUN;
          end
        end
        default: begin
          if (start_i) overlap_o <= 1'b1;
          if (cnt_q == '0) begin
            strobe_o <= 1'b1;
            state_q  <= TMR_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fifo_wr_delay.sv
module fifo_wr_delay #(
  parameter int TICK_NS    = 40,
  parameter int BASE_NS    = 400,
  parameter int TYPE_W     = 4,
  parameter int DATA_W     = 16,
  parameter int SUB_W      = 3,
  parameter int ADDR_W     = 4,
  parameter int FIRST_ADDR = 3,
  parameter bit SINGLE_SUB = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issued_i,
  input  logic [TYPE_W-1:0] mod_type_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              fifo_wr_o,
  output logic              overlap_err_o
);
  localparam int BASE_TICKS = BASE_NS / TICK_NS;

  logic [SUB_W-1:0] sub_sel;
  logic             tmr_busy;

  fwd_cfg_regs #(
    .TYPE_W(TYPE_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W),
    .FIRST_ADDR(FIRST_ADDR), .SINGLE_SUB(SINGLE_SUB)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .type_i (mod_type_i),
    .rdata_o(cfg_rdata_o),
    .sub_o  (sub_sel)
  );

  fwd_timer #(.SUB_W(SUB_W), .BASE_TICKS(BASE_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rd_issued_i),
    .sub_i    (sub_sel),
    .busy_o   (tmr_busy),
    .strobe_o (fifo_wr_o),
    .overlap_o(overlap_err_o)
  );

endmodule

// File: rtl/fifo_wr_delay_chk.sv
module fifo_wr_delay_chk #(
  parameter int DATA_W     = 16,
  parameter int SUB_W      = 3,
  parameter int BASE_TICKS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_issued_i,
  input logic              busy_i,
  input logic              fifo_wr_o,
  input logic              overlap_err_o,
  input logic [DATA_W-1:0] cfg_rdata_o
);
  localparam int MIN_TICKS = BASE_TICKS - (2 ** SUB_W - 1);
  localparam int WIN_W     = $clog2(BASE_TICKS + 2) + 1;
  localparam logic [DATA_W-1:0] MASK = DATA_W'(fwd_pkg::used_mask(DATA_W, SUB_W));

  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    win_q <= '0;
    else if (rd_issued_i && !busy_i) win_q <= WIN_W'(1);
    else if (busy_i)                 win_q <= win_q + 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issued_i && !busy_i |=> busy_i);                                     // R4
  AST_WINDOW_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> win_q <= WIN_W'(BASE_TICKS));                                // R4
  AST_STROBE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (win_q >= WIN_W'(MIN_TICKS + 1)) && (win_q <= WIN_W'(BASE_TICKS + 1))); // R4
  AST_OVERLAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issued_i && busy_i |=> overlap_err_o);                               // R5
  AST_NO_FALSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !overlap_err_o);                                            // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> !fifo_wr_o);                                              // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !fifo_wr_o);                                                // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~MASK) == '0);                                           // R2

endmodule

bind fifo_wr_delay fifo_wr_delay_chk #(
  .DATA_W(DATA_W), .SUB_W(SUB_W), .BASE_TICKS(BASE_TICKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_issued_i  (rd_issued_i),
  .busy_i       (tmr_busy),
  .fifo_wr_o    (fifo_wr_o),
  .overlap_err_o(overlap_err_o),
  .cfg_rdata_o  (cfg_rdata_o)
);

// File: tb/tb_fifo_wr_delay.sv
module tb_fifo_wr_delay;
  localparam int CLK_PERIOD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  mtype = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, rdata_s;
  logic        fifo_wr, ovl, fifo_wr_s, ovl_s;

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  int exp_q[$];
  int single_last = -1;
  bit done = 1'b0;
  logic [15:0] regs_m [4];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fifo_wr_delay dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_issued_i(rd), .mod_type_i(mtype),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .fifo_wr_o(fifo_wr), .overlap_err_o(ovl)
  );

  fifo_wr_delay #(.SINGLE_SUB(1'b1)) dut_single (
    .clk_i(clk), .rst_ni(rst_n), .rd_issued_i(rd), .mod_type_i(mtype),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata_s), .fifo_wr_o(fifo_wr_s), .overlap_err_o(ovl_s)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int sub_of(logic [3:0] t);
    return int'((regs_m[t[3:2]] >> (4 * int'(t[1:0]))) & 16'h7);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected strobe", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 strobe cycle", cyc, e);
      end
    end
    if (rst_n && fifo_wr_s) single_last = cyc;
  end

  task automatic cfg_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a >= 4'd3 && a <= 4'd6) regs_m[a - 4'd3] = d & 16'h7777;
  endtask

  task automatic cfg_check(logic [3:0] a, logic [15:0] expv, string req);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata == expv, req, int'(rdata), int'(expv));
  endtask

  task automatic issue_read(logic [3:0] t, output int k);
    @(negedge clk);
    mtype = t; rd = 1'b1;
    k = cyc + 1;
    exp_q.push_back(k + 10 - sub_of(t));
    @(negedge clk);
    rd = 1'b0;
    check(ovl == 1'b0, "R5 accepted read flags no error", int'(ovl), 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int k;
    for (int i = 0; i < 4; i++) regs_m[i] = '0;
    repeat (3) @(negedge clk);
    check(fifo_wr == 1'b0, "R1 strobe low in reset", int'(fifo_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fifo_wr == 1'b0 && ovl == 1'b0, "R1 outputs low after reset", int'({fifo_wr, ovl}), 0);
    for (int a = 3; a <= 6; a++) cfg_check(4'(a), 16'h0000, "R1 word zero after reset");

    // R1/R4: unprogrammed type waits full base
    issue_read(4'd9, k);
    idle(12);

    // R2: storage, masking, out-of-range addresses
    cfg_write(4'd3, 16'h0331);
    cfg_check(4'd3, 16'h0331, "R2 readback addr3");
    cfg_write(4'd4, 16'hFFFF);
    cfg_check(4'd4, 16'h7777, "R2 unused bits zero");
    cfg_write(4'd2, 16'hFFFF);
    cfg_check(4'd2, 16'h0000, "R2 addr2 reads zero");
    cfg_check(4'd3, 16'h0331, "R2 addr2 write no effect");
    cfg_write(4'd7, 16'hFFFF);
    cfg_check(4'd7, 16'h0000, "R2 addr7 reads zero");
    cfg_check(4'd6, 16'h0000, "R2 addr7 write no effect");
    cfg_write(4'd5, 16'h0007);
    cfg_write(4'd6, 16'h5000);
    cfg_check(4'd6, 16'h5000, "R2 readback addr6");

    // R3/R4: per-type field selection
    for (int t = 0; t < 16; t++) begin
      issue_read(4'(t), k);
      idle(11);
    end

    // R5: overlap ignored and flagged
    issue_read(4'd3, k);
    idle(1);
    @(negedge clk);
    mtype = 4'd8; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(ovl == 1'b1, "R5 overlap flagged", int'(ovl), 1);
    idle(12);
    check(exp_q.size() == 0, "R5 ignored read gave no strobe", exp_q.size(), 0);

    // R6: subtractor captured at acceptance
    issue_read(4'd1, k);
    mtype = 4'd0;
    cfg_write(4'd3, 16'h0000);
    idle(10);
    cfg_write(4'd3, 16'h0331);

    // R8: read accepted in strobe cycle
    issue_read(4'd8, k);
    idle(2);
    issue_read(4'd8, k);
    idle(6);
    check(exp_q.size() == 0, "R8 back-to-back strobes", exp_q.size(), 0);

    // R7: single-subtractor variant uses addr3 field A (=1 -> 9 ticks)
    issue_read(4'd2, k);
    idle(12);
    check(single_last == k + 9, "R7 single variant type2", single_last, k + 9);
    issue_read(4'd15, k);
    idle(12);
    check(single_last == k + 9, "R7 single variant type15", single_last, k + 9);

    check(exp_q.size() == 0, "R8 all strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule